// File: doc/BRIEF.md
# Piecewise-Linear Sine Frequency Synthesizer Core

This core produces a digital sine wave whose frequency is set by a tuning word. Every clock the tuning word is added into a wrapping phase register, and the phase is turned into one signed sine sample per cycle. The output frequency is the clock frequency times the tuning word divided by 2^16. No lookup memory and no multiplier are used. The phase is cut down to a coarse angle and folded into a single quarter wave. That quarter wave is covered by eight equal-width straight-line pieces. Each piece has a slope made from at most two shifted copies of the position inside the piece, and a fixed starting level. A single three-input adder combines these terms.

The core sits in front of an external converter that accepts two's complement samples. The tuning word may change on any cycle. The new word enters the phase register on the next edge, because there is no pipeline between the phase register and the output register. The piece levels were chosen to keep the output spectrum clean, not to keep each sample error small. So small steps between neighbouring pieces are expected, and the peak reaches only 123/128 of full scale.

Top module: `ddsSineCore`

## Requirements
- R1: On every clock edge with reset low, the 16-bit phase register takes the value (phase + fcw) mod 2^16.
- R2: Only the upper 12 bits of the phase register (bits 15..4) affect the sample, so phase values that differ only in bits 3..0 give the same sample.
- R3: Phase bit 15 selects the sign. When it is set, the output is the two's complement negative of the magnitude. When it is clear, the output is the magnitude with bit 7 equal to 0.
- R4: When phase bit 14 is set, phase bits 13..4 are inverted bit by bit before the piece is decoded. Phase 0x4000 therefore gives magnitude 123, and phase 0x8000 gives 0.
- R5: The folded bits 9..7 pick piece k, and bits 6..0 are the offset d. The slope-times-offset term, counted in 1/8192 steps, is 12d for pieces 0 and 1, 10d for piece 2, 9d for piece 3, 8d for piece 4, 6d for piece 5, 4d for piece 6 and d for piece 7.
- R6: The starting levels of pieces 0 to 7, counted in 1/1024 steps, are 0, 191, 384, 552, 697, 819, 909 and 971. They are added as the value times 8 in the 13-bit sum.
- R7: The 7-bit magnitude is bits 12..6 of the 13-bit sum plus bit 5 (round half up). For example, piece 0 with d = 3 gives 1, not 0.
- R8: The output magnitude never exceeds 123. The output stays within -123..+123.
- R9: The output is registered. After an edge with reset low it shows the sample for the phase held before that edge. A synchronous reset clears both the phase register and the output to 0.
- R10: A new fcw value is added on the first edge after it is applied. The output reflects it one edge later, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears phase and output |
| fcw | input | 16 | Frequency tuning word added to the phase every cycle |
| sampleOut | output | 8 | Signed sine sample, two's complement |

## Verification
The bench steps the coarse phase through all 4096 values and compares each sample with an arithmetic model. It also sweeps odd tuning words such as 10001 and 65535 that wrap through bit 15 at uneven points. A design with a wrong slope or level in any piece, or with the fold applied in the wrong quadrants, would differ from the model at some phase. The quadrant corners 0x4000 and 0xC000 are checked directly: a missing ones'-complement fold gives 0 there instead of ±123, and a flipped sign rule gives +123 where -123 is due. A fine tuning word of 1 exposes two faults. Leaking the four dropped phase bits makes the output change inside a 16-step group. Truncating instead of rounding holds the first nonzero sample at 0. Changing the tuning word and applying reset in the middle of a run catch an extra cycle of latency or an output register that is not cleared.

// File: rtl/ddsPkg.sv
package ddsPkg;

  localparam int ACC_W   = 16;
  localparam int PH_W    = 12;
  localparam int SEG_W   = 3;
  localparam int OFF_W   = 7;
  localparam int FRAC_W  = 3;
  localparam int ICPT_W  = 10;
  localparam int OUT_W   = 8;
  localparam int MAG_W   = OUT_W - 1;
  localparam int SUM_W   = ICPT_W + FRAC_W;
  localparam int RND_POS = SUM_W - MAG_W - 1;
  localparam int NUM_TERM = 2;

  // Which shifted copy of the in-piece offset a slope term contributes.
  typedef enum logic [2:0] {
    SH_NONE = 3'd0,
    SH_R0   = 3'd1,
    SH_R1   = 3'd2,
    SH_R2   = 3'd3,
    SH_R3   = 3'd4
  } shiftSel_e;

  // Strobes passed from phase control to the amplitude datapath.
  typedef struct packed {
    shiftSel_e [NUM_TERM-1:0] termSel;
    logic [SEG_W-1:0]         segIdx;
    logic [OFF_W-1:0]         offset;
    logic                     negate;
  } ampStrobe_t;

  // Slope of each piece expressed as two shift selections.
  function automatic shiftSel_e slopeTerm(input logic [SEG_W-1:0] seg, input int unsigned t);
    shiftSel_e hi;
    shiftSel_e lo;
    case (seg)
      3'd0, 3'd1: begin hi = SH_R0; lo = SH_R1;   end
      3'd2:       begin hi = SH_R0; lo = SH_R2;   end
      3'd3:       begin hi = SH_R0; lo = SH_R3;   end
      3'd4:       begin hi = SH_R0; lo = SH_NONE; end
      3'd5:       begin hi = SH_R1; lo = SH_R2;   end
      3'd6:       begin hi = SH_R1; lo = SH_NONE; end
      default:    begin hi = SH_R3; lo = SH_NONE; end
    endcase
    return (t == 0) ? hi : lo;
  endfunction

  // Starting level of each piece in 1/1024 of full scale.
  function automatic logic [ICPT_W-1:0] segIntercept(input logic [SEG_W-1:0] seg);
    logic [ICPT_W-1:0] lvl;
    case (seg)
      3'd0:    lvl = 10'd0;
      3'd1:    lvl = 10'd191;
      3'd2:    lvl = 10'd384;
      3'd3:    lvl = 10'd552;
      3'd4:    lvl = 10'd697;
      3'd5:    lvl = 10'd819;
      3'd6:    lvl = 10'd909;
      default: lvl = 10'd971;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/ddsShiftTerm.sv
module ddsShiftTerm
  import ddsPkg::*;
#(
  parameter int OFFW = OFF_W,
  parameter int FRW  = FRAC_W,
  parameter int SW   = SUM_W
) (
  input  shiftSel_e        sel,
  input  logic [OFFW-1:0]  offset,
  output logic [SW-1:0]    term
);

  localparam int ALN_W = OFFW + FRW;
  localparam int PAD_W = SW - ALN_W;

  logic [ALN_W-1:0] aligned;
  logic [ALN_W-1:0] shifted;

  assign aligned = {offset, {FRW{1'b0}}};

  always_comb begin
    case (sel)
      SH_R0:   shifted = aligned;
      SH_R1:   shifted = aligned >> 1;
      SH_R2:   shifted = aligned >> 2;
      SH_R3:   shifted = aligned >> 3;
      default: shifted = '0;
    endcase
  end

  assign term = {{PAD_W{1'b0}}, shifted};

endmodule

// File: rtl/ddsPhaseCtl.sv
module ddsPhaseCtl
  import ddsPkg::*;
#(
  parameter int AW   = ACC_W,
  parameter int PW   = PH_W,
  parameter int SGW  = SEG_W,
  parameter int OFFW = OFF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] fcw,
  output logic [AW-1:0] phaseAcc,
  output ampStrobe_t    strobe
);

  localparam int FOLD_W = PW - 2;

  logic [PW-1:0]     truncPhase;
  logic              signBit;
  logic              mirrorBit;
  logic [FOLD_W-1:0] foldedPhase;
  logic [SGW-1:0]    segSel;

  always_ff @(posedge clk) begin
    if (rst) phaseAcc <= '0;
    else     phaseAcc <= phaseAcc + fcw;
  end

  assign truncPhase  = phaseAcc[AW-1 -: PW];
  assign signBit     = truncPhase[PW-1];
  assign mirrorBit   = truncPhase[PW-2];
  assign foldedPhase = truncPhase[FOLD_W-1:0] ^ {FOLD_W{mirrorBit}};
  assign segSel      = foldedPhase[FOLD_W-1 -: SGW];

  assign strobe.segIdx = segSel;
  assign strobe.offset = foldedPhase[OFFW-1:0];
  assign strobe.negate = signBit;

  for (genvar t = 0; t < NUM_TERM; t++) begin : g_termSel
    assign strobe.termSel[t] = slopeTerm(segSel, t);
  end

endmodule

// File: rtl/ddsAmpPath.sv
module ddsAmpPath
  import ddsPkg::*;
#(
  parameter int OW = OUT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  ampStrobe_t    strobe,
  output logic [OW-1:0] sampleOut
);

  localparam int MW = OW - 1;

  logic [SUM_W-1:0] termVal [NUM_TERM];
  logic [SUM_W-1:0] icptTerm;
  logic [SUM_W-1:0] sumVal;
  logic [MW:0]      magWide;
  logic [MW-1:0]    magnitude;
  logic [OW-1:0]    unsignedMag;
  logic [OW-1:0]    signedSample;

  for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
    ddsShiftTerm #(
      .OFFW(OFF_W),
      .FRW (FRAC_W),
      .SW  (SUM_W)
    ) u_term (
      .sel   (strobe.termSel[t]),
      .offset(strobe.offset),
      .term  (termVal[t])
    );
  end

  assign icptTerm = {segIntercept(strobe.segIdx), {FRAC_W{1'b0}}};
  assign sumVal   = termVal[0] + termVal[1] + icptTerm;

  // Round half up: keep the top bits, add the first dropped bit.
  assign magWide     = {1'b0, sumVal[SUM_W-1 -: MW]} + {{MW{1'b0}}, sumVal[RND_POS]};
  assign magnitude   = magWide[MW-1:0];
  assign unsignedMag = {1'b0, magnitude};
  assign signedSample = strobe.negate ? (~unsignedMag + 1'b1) : unsignedMag;

  always_ff @(posedge clk) begin
    if (rst) sampleOut <= '0;
    else     sampleOut <= signedSample;
  end

endmodule

// File: rtl/ddsSineCore.sv
module ddsSineCore
  import ddsPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] fcw,
  output logic [OUT_W-1:0] sampleOut
);

  logic [ACC_W-1:0] phaseAcc;
  ampStrobe_t       ampStrobe;

  ddsPhaseCtl #(
    .AW  (ACC_W),
    .PW  (PH_W),
    .SGW (SEG_W),
    .OFFW(OFF_W)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .fcw     (fcw),
    .phaseAcc(phaseAcc),
    .strobe  (ampStrobe)
  );

  ddsAmpPath #(
    .OW(OUT_W)
  ) u_amp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (ampStrobe),
    .sampleOut(sampleOut)
  );

endmodule

// File: rtl/ddsSineCoreChk.sv
module ddsSineCoreChk #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] fcw,
  input logic [AW-1:0] phaseAcc,
  input logic [OW-1:0] sampleOut
);

  logic primed;
  logic rstQ;

  initial begin
    primed = 1'b0;
    rstQ   = 1'b0;
  end

  always @(posedge clk) begin
    rstQ <= rst;
    if (rst) primed <= 1'b1;
  end

  // R9: the edge after a reset edge leaves phase and sample at zero
  always @(posedge clk) begin
    if (primed && rstQ) begin
      assert_reset_clear_R9: assert (sampleOut == '0 && phaseAcc == '0)
        else $error("reset did not clear state");
    end
  end

  assert_acc_step_R1: assert property (@(posedge clk) disable iff (rst || !primed)
    !$past(rst) |-> (phaseAcc == AW'($past(phaseAcc) + $past(fcw))));

  assert_peak_R8: assert property (@(posedge clk) disable iff (rst || !primed)
    ($signed(sampleOut) <= 8'sd123) && ($signed(sampleOut) >= -8'sd123));

  assert_sign_R3: assert property (@(posedge clk) disable iff (rst || !primed)
    sampleOut[OW-1] |-> $past(phaseAcc[AW-1]));

  assert_fold_peak_R4: assert property (@(posedge clk) disable iff (rst || !primed)
    (!$past(rst) && $past(phaseAcc[AW-2:AW-12]) == 11'h400)
      |-> (sampleOut == ($past(phaseAcc[AW-1]) ? 8'h85 : 8'd123)));

  assert_zero_level_R6: assert property (@(posedge clk) disable iff (rst || !primed)
    (!$past(rst) && $past(phaseAcc[AW-2:AW-12]) == 11'h000) |-> (sampleOut == '0));

endmodule

bind ddsSineCore ddsSineCoreChk #(.AW(16), .OW(8)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fcw      (fcw),
  .phaseAcc (phaseAcc),
  .sampleOut(sampleOut)
);

// File: tb/ddsSineCore_bench.sv
`timescale 1ns/1ps
module ddsSineCore_bench;

  logic        clk;
  logic        rst;
  logic [15:0] fcw;
  logic [7:0]  sampleOut;

  int total;
  int bad;
  logic [15:0] mAcc;
  logic [7:0]  expOut;

  localparam int NVEC = 6;
  localparam logic [15:0] VEC_FCW [NVEC] = '{16'd16, 16'd1, 16'd10001, 16'h4000, 16'd65535, 16'h1234};
  localparam int          VEC_LEN [NVEC] = '{4100, 80, 400, 12, 400, 400};

  ddsSineCore u_ddsSineCore (
    .clk      (clk),
    .rst      (rst),
    .fcw      (fcw),
    .sampleOut(sampleOut)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Sample model built from the requirements.
  function automatic logic [7:0] model(input logic [15:0] a);
    logic [11:0] p;
    logic [9:0]  f;
    int k, d, lvl, mult, s, m;
    p = a[15:4];
    f = p[10] ? ~p[9:0] : p[9:0];
    k = int'(f[9:7]);
    d = int'(f[6:0]);
    case (k)
      0: begin lvl = 0;   mult = 12; end
      1: begin lvl = 191; mult = 12; end
      2: begin lvl = 384; mult = 10; end
      3: begin lvl = 552; mult = 9;  end
      4: begin lvl = 697; mult = 8;  end
      5: begin lvl = 819; mult = 6;  end
      6: begin lvl = 909; mult = 4;  end
      default: begin lvl = 971; mult = 1; end
    endcase
    s = lvl * 8 + mult * d;
    m = (s + 32) / 64;
    return p[11] ? 8'(-m) : 8'(m);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0d (0x%02h) expected %0d (0x%02h) at phase model 0x%04h",
               req, $signed(act), act, $signed(exp), exp, mAcc);
    end
  endtask

  // One edge; afterwards update the model and drive nothing until told.
  task automatic tick();
    @(posedge clk);
    #1;
    if (rst) begin
      expOut = 8'd0;
      mAcc   = 16'd0;
    end else begin
      expOut = model(mAcc);
      mAcc   = mAcc + fcw;
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;
    mAcc  = 16'd0;
    rst   = 1'b1;
    fcw   = 16'd777;
    @(negedge clk);

    // R9: reset state
    tick();
    tick();
    check("R9 reset output", sampleOut, 8'd0);

    // Vector table: sweep tuning words, compare every sample (R1 R5 R6 R7)
    for (int v = 0; v < NVEC; v++) begin
      fcw = VEC_FCW[v];
      doReset();
      for (int c = 0; c < VEC_LEN[v]; c++) begin
        tick();
        check("R5 R6 R1 sweep sample", sampleOut, expOut);
      end
    end

    // R4 R3 R8: quadrant corners with fcw 0x4000
    fcw = 16'h4000;
    doReset();
    tick(); check("R9 first sample after reset", sampleOut, 8'd0);
    tick(); check("R4 fold peak +123", sampleOut, 8'd123);
    tick(); check("R3 phase 0x8000 zero", sampleOut, 8'd0);
    tick(); check("R3 negative peak -123", sampleOut, 8'h85);

    // R2 R7: fine step, rounding and dropped low bits
    fcw = 16'd1;
    doReset();
    for (int c = 1; c <= 64; c++) begin
      tick();
      if (c == 48) check("R7 d=2 rounds to 0", sampleOut, 8'd0);
      if (c >= 49) check("R2 low bits ignored, R7 d=3 rounds to 1", sampleOut, 8'd1);
    end

    // R10: tuning word change takes effect on the next edge
    fcw = 16'h4000;
    doReset();
    tick();
    fcw = 16'd0;
    tick(); check("R10 old word applied", sampleOut, 8'd123);
    tick(); check("R10 zero word holds phase", sampleOut, 8'd123);
    fcw = 16'h4000;
    tick(); check("R10 held phase sample", sampleOut, 8'd123);
    tick(); check("R10 new word applied", sampleOut, 8'd0);

    // R9: reset in the middle of a run
    fcw = 16'd10001;
    for (int c = 0; c < 7; c++) tick();
    rst = 1'b1;
    tick(); check("R9 mid-run reset clears output", sampleOut, 8'd0);
    rst = 1'b0;
    tick(); check("R9 phase restarts at zero", sampleOut, 8'd0);
    tick(); check("R1 first step after reset", sampleOut, model(16'd10001));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule